// File: doc/BRIEF.md
# Super I/O configuration register controller

This block guards the configuration space of a multi-function legacy I/O chip. The space sits behind a two-byte window on a byte-wide host bus. Offset 0 of the window is the index port and offset 1 is the data port. The window is normally locked. Writing an unlock key to the index port opens configuration mode. The host then writes a register number to the index port and reads or writes that register through the data port. A lock key closes the window again. If the window was open at that moment, the block also emits a single-cycle commit pulse so that downstream address and interrupt decoders take up the new settings.

There are two kinds of register. Indices below 0x30 reach one shared global bank. Global register 0x07 holds a logical-device number. Indices from 0x30 upward reach the private bank of that device, and there are twelve such banks. A strap input moves the window between two base addresses. Two global registers report the base address that is in use.

The whole register file is brought out as flat vectors so that decoders can use any field directly. Reads are registered: the value appears on the cycle after the read strobe.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: The window is the two byte addresses at the base address, which is 0x002E when strap_i is 0 and 0x004E when strap_i is 1. An access to any other address changes nothing, and a read of such an address returns 0x00.
- R2: A write of 0x55 to offset 0 enters configuration mode and a write of 0xAA to offset 0 leaves it. Neither key value is ever stored as the index, and both keys act in either mode.
- R3: Outside configuration mode, index and data writes other than the unlock key are ignored, and every read returns 0x00.
- R4: In configuration mode, a read of offset 0 returns 0x00 and a read of offset 1 returns the addressed register. rdata_o shows the result in the cycle after rd_i and holds it until the next read.
- R5: An index below 0x30 addresses the global bank. Global register 0x07 holds the selected device number.
- R6: An index from 0x30 up to 0x30+DEV_SPAN-1 addresses register (index-0x30) of the selected device. The twelve banks (devices 0 to 11) are independent. Byte r of device d appears on cfg_dev_o[(d*DEV_SPAN+r)*8 +: 8].
- R7: When the selected device number is 12 or more, or the index lies beyond the device span, a data write is ignored and a data read returns 0x00.
- R8: Global registers 0x26 and 0x27 always read back the low and high bytes of the active base address, also on cfg_global_o. Data writes to them are ignored.
- R9: commit_o is a one-cycle pulse in the cycle after a lock-key write that found the block in configuration mode. A lock key written outside configuration mode gives no pulse.
- R10: Reset clears configuration mode, the index, rdata_o, commit_o and every bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_i | input | 1 | Base select: 0 gives 0x002E, 1 gives 0x004E |
| wr_i | input | 1 | Bus write strobe, one cycle per byte access |
| rd_i | input | 1 | Bus read strobe, one cycle per byte access |
| addr_i | input | ADDR_W | Bus byte address |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Registered read data |
| commit_o | output | 1 | One-cycle commit pulse on lock |
| cfg_global_o | output | GLB_REGS*8 | Global bank, byte i at bits [i*8 +: 8] |
| cfg_dev_o | output | NUM_DEV*DEV_SPAN*8 | All device banks, layout as in R6 |

## Verification
The hardest cases to reach are the ones that depend on state left behind by earlier accesses. Examples are a lock key that arrives while the block is already locked, a device number above the last bank, and an index that survives a lock and unlock cycle. The stimulus table therefore runs one long access sequence. Within it, the device number is changed between banks, moved out of range and moved back. The block is then locked, written while locked, unlocked again, and read at the index it kept. Last, directed steps flip the strap and apply a reset in the middle of operation. After each step the banks are read through the data port and on the flat outputs.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_OPEN   = 8'h55;
  localparam logic [7:0] KEY_CLOSE  = 8'hAA;
  localparam logic [7:0] IDX_DEVNUM = 8'h07;
  localparam logic [7:0] IDX_BASELO = 8'h26;
  localparam logic [7:0] IDX_BASEHI = 8'h27;

  // one decoded bus access
  typedef struct packed {
    logic open_key;
    logic close_key;
    logic idx_wr;
    logic dat_wr;
    logic dat_rd;
  } bus_acc_t;
endpackage

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_DFLT = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_ALT  = 16'h004E
) (
  input  logic              strap_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [ADDR_W-1:0] base_o,
  output bus_acc_t          acc_o
);
  logic hit;
  logic is_key;

  assign base_o = strap_i ? BASE_ALT : BASE_DFLT;
  assign hit    = (addr_i[ADDR_W-1:1] == base_o[ADDR_W-1:1]);
  assign is_key = (wdata_i == KEY_OPEN) || (wdata_i == KEY_CLOSE);

  always_comb begin
    acc_o.open_key  = wr_i && hit && !addr_i[0] && (wdata_i == KEY_OPEN);
    acc_o.close_key = wr_i && hit && !addr_i[0] && (wdata_i == KEY_CLOSE);
    acc_o.idx_wr    = wr_i && hit && !addr_i[0] && !is_key;
    acc_o.dat_wr    = wr_i && hit && addr_i[0];
    acc_o.dat_rd    = rd_i && hit && addr_i[0];
  end
endmodule

// File: rtl/sio_cfg_lock.sv
module sio_cfg_lock
  import sio_cfg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bus_acc_t acc_i,
  output logic     mode_o,
  output logic     commit_o
);
  logic mode_q, mode_d;
  logic commit_q, commit_d;

  always_comb begin
    mode_d   = mode_q;
    commit_d = 1'b0;
    if (acc_i.open_key) begin
      mode_d = 1'b1;
    end else if (acc_i.close_key) begin
      mode_d   = 1'b0;
      commit_d = mode_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      commit_q <= commit_d;
    end
  end

  assign mode_o   = mode_q;
  assign commit_o = commit_q;
endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank #(
  parameter int DEPTH = 48,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [7:0]         wdata_i,
  output logic [DEPTH*8-1:0] flat_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    logic [7:0] q;
    logic       en;
    assign en = we_i && (waddr_i == AW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= 8'h00;
      end else if (en) begin
        q <= wdata_i;
      end
    end
    assign flat_o[i*8 +: 8] = q;
  end
endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_DFLT = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_ALT  = 16'h004E,
  parameter int NUM_DEV  = 12,
  parameter int GLB_REGS = 48,
  parameter int DEV_SPAN = 80
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        strap_i,
  input  logic                        wr_i,
  input  logic                        rd_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [7:0]                  wdata_i,
  output logic [7:0]                  rdata_o,
  output logic                        commit_o,
  output logic [GLB_REGS*8-1:0]       cfg_global_o,
  output logic [NUM_DEV*DEV_SPAN*8-1:0] cfg_dev_o
);
  localparam int GLB_AW = $clog2(GLB_REGS);
  localparam int DEV_AW = $clog2(DEV_SPAN);
  localparam logic [7:0] GLB_LIM  = 8'(GLB_REGS);
  localparam logic [7:0] DEV_LIM  = 8'(DEV_SPAN);
  localparam logic [7:0] NDEV_LIM = 8'(NUM_DEV);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  bus_acc_t          acc;
  logic [ADDR_W-1:0] base;
  logic              cfg_mode;

  sio_cfg_decode #(
    .ADDR_W(ADDR_W), .BASE_DFLT(BASE_DFLT), .BASE_ALT(BASE_ALT)
  ) i_decode (
    .strap_i(strap_i), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .base_o(base), .acc_o(acc)
  );

  sio_cfg_lock i_lock (
    .clk_i(clk_i), .rst_ni(rst_q), .acc_i(acc),
    .mode_o(cfg_mode), .commit_o(commit_o)
  );

  // index register
  logic [7:0] idx_q, idx_d;
  always_comb begin
    idx_d = idx_q;
    if (cfg_mode && acc.idx_wr) idx_d = wdata_i;
  end
  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) idx_q <= 8'h00;
    else        idx_q <= idx_d;
  end

  // address split
  logic [GLB_REGS*8-1:0] glb_flat;
  logic [7:0]            dev_num;
  logic [7:0]            dev_off;
  logic                  is_glb;
  logic                  is_base;
  logic                  dev_ok;
  logic                  glb_we;
  logic [NUM_DEV-1:0]    dev_we;

  assign is_glb  = idx_q < GLB_LIM;
  assign is_base = (idx_q == IDX_BASELO) || (idx_q == IDX_BASEHI);
  assign dev_num = glb_flat[int'(IDX_DEVNUM)*8 +: 8];
  assign dev_off = idx_q - GLB_LIM;
  assign dev_ok  = (dev_num < NDEV_LIM) && (dev_off < DEV_LIM);
  assign glb_we  = cfg_mode && acc.dat_wr && is_glb && !is_base;

  sio_cfg_bank #(.DEPTH(GLB_REGS), .AW(GLB_AW)) i_glb_bank (
    .clk_i(clk_i), .rst_ni(rst_q), .we_i(glb_we),
    .waddr_i(idx_q[GLB_AW-1:0]), .wdata_i(wdata_i), .flat_o(glb_flat)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign dev_we[d] = cfg_mode && acc.dat_wr && !is_glb && dev_ok
                       && (dev_num == 8'(d));
    sio_cfg_bank #(.DEPTH(DEV_SPAN), .AW(DEV_AW)) i_dev_bank (
      .clk_i(clk_i), .rst_ni(rst_q), .we_i(dev_we[d]),
      .waddr_i(dev_off[DEV_AW-1:0]), .wdata_i(wdata_i),
      .flat_o(cfg_dev_o[d*DEV_SPAN*8 +: DEV_SPAN*8])
    );
  end

  // global view with the base bytes mirrored from the strap
  always_comb begin
    cfg_global_o = glb_flat;
    cfg_global_o[int'(IDX_BASELO)*8 +: 8] = base[7:0];
    cfg_global_o[int'(IDX_BASEHI)*8 +: 8] = 8'(base >> 8);
  end

  // read path
  logic [7:0] rd_val;
  always_comb begin
    rd_val = 8'h00;
    if (cfg_mode && acc.dat_rd) begin
      if (is_glb) begin
        rd_val = cfg_global_o[int'(idx_q)*8 +: 8];
      end else if (dev_ok) begin
        rd_val = cfg_dev_o[(int'(dev_num)*DEV_SPAN + int'(dev_off))*8 +: 8];
      end
    end
  end

  logic [7:0] rdata_q, rdata_d;
  always_comb begin
    rdata_d = rdata_q;
    if (rd_i) rdata_d = rd_val;
  end
  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) rdata_q <= 8'h00;
    else        rdata_q <= rdata_d;
  end
  assign rdata_o = rdata_q;
endmodule

module sio_cfg_ctrl_chk #(
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_DFLT = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_ALT  = 16'h004E,
  parameter int GLB_REGS = 48
) (
  input logic                  clk_i,
  input logic                  rst_q,
  input logic                  strap_i,
  input logic                  wr_i,
  input logic                  rd_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [7:0]            wdata_i,
  input logic [7:0]            rdata_o,
  input logic                  commit_o,
  input logic                  cfg_mode,
  input logic [GLB_REGS*8-1:0] cfg_global_o
);
  logic [ADDR_W-1:0] wbase;
  assign wbase = strap_i ? BASE_ALT : BASE_DFLT;

  // R9: pulse lasts one cycle
  assert_commit_single_R9: assert property (@(posedge clk_i) disable iff (!rst_q)
    commit_o |=> !commit_o);

  // R9: pulse only after a lock key that found the block unlocked
  assert_commit_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_q)
    commit_o |-> ($past(wr_i && addr_i == wbase && wdata_i == 8'hAA) && $past(cfg_mode)));

  // R2: unlock key opens the window
  assert_open_key_R2: assert property (@(posedge clk_i) disable iff (!rst_q)
    (wr_i && addr_i == wbase && wdata_i == 8'h55) |=> cfg_mode);

  // R3: locked reads return zero
  assert_locked_read_R3: assert property (@(posedge clk_i) disable iff (!rst_q)
    (rd_i && !cfg_mode) |=> (rdata_o == 8'h00));

  // R4: index port reads return zero
  assert_index_read_R4: assert property (@(posedge clk_i) disable iff (!rst_q)
    (rd_i && addr_i == wbase) |=> (rdata_o == 8'h00));

  // R8: base bytes track the strap
  assert_base_mirror_R8: assert property (@(posedge clk_i) disable iff (!rst_q)
    (cfg_global_o[16'h26*8 +: 8] == wbase[7:0]));
endmodule

bind sio_cfg_ctrl sio_cfg_ctrl_chk #(
  .ADDR_W(ADDR_W), .BASE_DFLT(BASE_DFLT), .BASE_ALT(BASE_ALT), .GLB_REGS(GLB_REGS)
) i_chk (
  .clk_i(clk_i), .rst_q(rst_q), .strap_i(strap_i), .wr_i(wr_i), .rd_i(rd_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .commit_o(commit_o),
  .cfg_mode(cfg_mode), .cfg_global_o(cfg_global_o)
);

// File: tb/test_sio_cfg_ctrl.sv
module test_sio_cfg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_DEV  = 12;
  localparam int GLB_REGS = 48;
  localparam int DEV_SPAN = 80;
  localparam int NVEC = 56;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        strap_i;
  logic        wr_i, rd_i;
  logic [15:0] addr_i;
  logic [7:0]  wdata_i;
  logic [7:0]  rdata_o;
  logic        commit_o;
  logic [GLB_REGS*8-1:0]         cfg_global_o;
  logic [NUM_DEV*DEV_SPAN*8-1:0] cfg_dev_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sio_cfg_ctrl i_sio_cfg_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .commit_o(commit_o),
    .cfg_global_o(cfg_global_o), .cfg_dev_o(cfg_dev_o)
  );

  // {op, offset, data, expected, commit, req}: op 1 = read, 0 = write
  localparam logic [35:0] VEC [NVEC] = '{
    36'h1_0_00_00_0_03, // R3 locked read
    36'h0_0_07_00_0_03, // R3 locked index write
    36'h0_1_05_00_0_03, // R3 locked data write
    36'h1_1_00_00_0_03,
    36'h0_0_55_00_0_02, // R2 unlock
    36'h1_0_00_00_0_04, // R4 index read
    36'h0_0_07_00_0_05,
    36'h1_1_00_00_0_03, // R3 earlier write dropped
    36'h0_1_04_00_0_05,
    36'h1_1_00_04_0_05, // R5 device number
    36'h0_0_30_00_0_06,
    36'h0_1_01_00_0_06,
    36'h1_1_00_01_0_06, // R6 device 4
    36'h0_0_07_00_0_06,
    36'h0_1_05_00_0_06,
    36'h0_0_30_00_0_06,
    36'h1_1_00_00_0_06, // R6 device 5 separate
    36'h0_1_77_00_0_06,
    36'h1_1_00_77_0_06,
    36'h0_0_07_00_0_06,
    36'h0_1_04_00_0_06,
    36'h0_0_30_00_0_06,
    36'h1_1_00_01_0_06, // R6 device 4 kept
    36'h0_0_26_00_0_08,
    36'h1_1_00_2E_0_08, // R8 base low
    36'h0_1_99_00_0_08,
    36'h1_1_00_2E_0_08, // R8 write ignored
    36'h0_0_27_00_0_08,
    36'h1_1_00_00_0_08, // R8 base high
    36'h0_0_10_00_0_02,
    36'h0_1_55_00_0_02, // R2 key on data port is data
    36'h1_1_00_55_0_02,
    36'h0_0_07_00_0_07,
    36'h0_1_0C_00_0_07,
    36'h0_0_30_00_0_07,
    36'h0_1_12_00_0_07,
    36'h1_1_00_00_0_07, // R7 device 12 out of range
    36'h0_0_07_00_0_07,
    36'h0_1_0B_00_0_07,
    36'h0_0_30_00_0_07,
    36'h1_1_00_00_0_07, // R7 write to device 12 did not land
    36'h0_1_21_00_0_06,
    36'h1_1_00_21_0_06, // R6 last device
    36'h0_0_80_00_0_07,
    36'h0_1_33_00_0_07,
    36'h1_1_00_00_0_07, // R7 beyond span
    36'h0_0_7F_00_0_06,
    36'h0_1_44_00_0_06,
    36'h1_1_00_44_0_06, // R6 top of span
    36'h0_0_AA_00_1_09, // R9 lock with commit
    36'h1_1_00_00_0_03,
    36'h0_1_66_00_0_03,
    36'h0_0_AA_00_0_09, // R9 lock while locked: no pulse
    36'h0_0_55_00_0_02,
    36'h1_1_00_44_0_02, // R2 index kept, key not stored
    36'h0_0_AA_00_1_09
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d,
                        input logic exp_c, input string req);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
    check(req, int'(commit_o), int'(exp_c));
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
    check(req, int'(rdata_o), int'(exp));
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; strap_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0;
    addr_i = 16'h0; wdata_i = 8'h0;
    repeat (3) @(negedge clk_i);
    check("R10 reset rdata", int'(rdata_o), 0);
    check("R10 reset commit", int'(commit_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      logic [35:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[7:0], i);
      if (v[32]) bus_rd(16'h002E + 16'(v[31:28]), v[19:12], tag);
      else       bus_wr(16'h002E + 16'(v[31:28]), v[27:20], v[8], tag);
    end

    // R6 flat outputs
    check("R6 flat dev4", int'(cfg_dev_o[(4*DEV_SPAN+0)*8 +: 8]), 8'h01);
    check("R6 flat dev11", int'(cfg_dev_o[(11*DEV_SPAN+79)*8 +: 8]), 8'h44);
    check("R8 flat base", int'(cfg_global_o[8'h26*8 +: 8]), 8'h2E);

    // R1 other addresses do nothing
    bus_wr(16'h004E, 8'h55, 1'b0, "R1 alt base unused");
    bus_rd(16'h002F, 8'h00, "R1 still locked");
    bus_wr(16'h0030, 8'h55, 1'b0, "R1 outside window");
    bus_rd(16'h002F, 8'h00, "R1 still locked");

    // R1 strap moves the window
    strap_i = 1'b1;
    @(negedge clk_i);
    check("R8 flat base strap", int'(cfg_global_o[8'h26*8 +: 8]), 8'h4E);
    bus_wr(16'h004E, 8'h55, 1'b0, "R1 unlock alt");
    bus_wr(16'h004E, 8'h26, 1'b0, "R1 index alt");
    bus_rd(16'h004F, 8'h4E, "R1 alt base read");
    bus_wr(16'h002E, 8'hAA, 1'b0, "R1 old base ignored");
    bus_rd(16'h004F, 8'h4E, "R1 still unlocked");

    // R10 mid-run reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R10 bank cleared", int'(cfg_dev_o[(4*DEV_SPAN+0)*8 +: 8]), 0);
    check("R10 devnum cleared", int'(cfg_global_o[8'h07*8 +: 8]), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    bus_rd(16'h004F, 8'h00, "R10 locked after reset");
    bus_wr(16'h004E, 8'h55, 1'b0, "R10 unlock");
    bus_wr(16'h004E, 8'h07, 1'b0, "R10 index");
    bus_rd(16'h004F, 8'h00, "R10 device number zero");
    bus_wr(16'h004E, 8'hAA, 1'b1, "R9 commit after reset");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule